// File: doc/BRIEF.md
# Reference Clock Switchover Controller

The block picks which of two reference clocks, REF1 or REF2, feeds a downstream PLL. Both references are brought into a faster system clock domain through synchronizers, and their rising edges are found there. The selection can be set by hand, from a register bit or from an external select pin, or it can follow an automatic policy. The automatic policy moves to REF2 once REF1 has gone silent and may move back once REF1 is healthy again.

REF1 health is judged only by the relative order of edges on the two references, with REF2 used as the timebase. A silent REF1 is recognised after a run of REF2 edges with no REF1 edge between them. A recovered REF1 is recognised after a run of REF1 edges that no long REF2 run interrupts. In both directions the actual change of selection waits a fixed number of further REF2 edges. A hold setting keeps the block on REF2 after REF1 recovers, until software takes manual control again.

The output is a selection level, a one-cycle marker on each change of selection, and a level that is high while REF1 is considered absent. The glitch-free clock multiplexer and the PLL are outside this block.

Top module: `refclk_switchover`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sel_ref2 is 0 (REF1 selected), sel_change is 0 and ref1_lost is 0.
- R2: With auto_en=0 and man_src_pin=0, sel_ref2 follows man_reg_sel (0 selects REF1, 1 selects REF2) and sel_pin has no effect.
- R3: With auto_en=0 and man_src_pin=1, sel_ref2 follows the synchronized sel_pin and man_reg_sel has no effect.
- R4: ref1_lost rises when three REF2 rising edges occur in a row with no REF1 rising edge between them; this detection runs in every mode.
- R5: A REF1 rising edge restarts the REF2 run, so two REF2 edges, a REF1 edge and two more REF2 edges leave ref1_lost at 0.
- R6: With auto_en=1, after ref1_lost rises the selection changes to REF2 on the second REF2 rising edge that follows, and not earlier.
- R7: ref1_lost falls when four REF1 rising edges occur while lost with no run of three REF2 edges between them.
- R8: A run of three REF2 edges while lost restarts the REF1 recovery count from zero.
- R9: With auto_en=1 and revert_hold=0, after ref1_lost falls the selection returns to REF1 on the second REF2 rising edge that follows.
- R10: With auto_en=1 and revert_hold=1, recovery of REF1 leaves REF2 selected; clearing auto_en then applies the manual selection.
- R11: sel_change is high for exactly the one cycle in which sel_ref2 takes a new value, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times faster than either reference |
| rst_n | input | 1 | Active-low synchronous reset |
| ref1_in | input | 1 | Primary reference clock, asynchronous |
| ref2_in | input | 1 | Backup reference clock, asynchronous |
| auto_en | input | 1 | 1 selects automatic switchover, 0 manual |
| revert_hold | input | 1 | 1 keeps REF2 after REF1 recovers, 0 returns to REF1 |
| man_src_pin | input | 1 | Manual source: 1 uses sel_pin, 0 uses man_reg_sel |
| man_reg_sel | input | 1 | Register select bit, 1 chooses REF2 |
| sel_pin | input | 1 | External select pin, asynchronous, 1 chooses REF2 |
| sel_ref2 | output | 1 | Current selection, 1 means REF2 |
| sel_change | output | 1 | One-cycle marker of a selection change |
| ref1_lost | output | 1 | High while REF1 is considered absent |

## Verification
Every cycle, the assertions check that the change marker matches a real change of selection, that the register bit drives the selection in register mode, that the REF2 run counter stays bounded, that the loss flag only rises on a REF2 edge and only falls on a REF1 edge, and that an automatic change happens only right after a REF2 edge. How many edges each decision takes, the restart of a count by the opposite reference, the two-edge delay and the revertive or holding policy only show up in the bench's edge sequences. Those sequences sweep the number of REF2 edges after reset and interleave the two references in fixed orders.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic {
    PICK_REF1 = 1'b0,
    PICK_REF2 = 1'b1
  } ref_pick_e;

  typedef struct packed {
    logic auto_en;
    logic hold_ref2;
    logic src_pin;
    logic reg_pick;
  } swo_ctrl_t;

endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/refsw_monitor.sv
module refsw_monitor #(
  parameter int LOSS_RUN   = 3,
  parameter int RETURN_RUN = 4,
  parameter int ARM_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref1_lvl,
  input  logic ref2_lvl,
  output logic ref1_edge,
  output logic ref2_edge,
  output logic lost,
  output logic sw_done,
  output logic sw_to_ref2
);

  localparam int RUN_W = $clog2(LOSS_RUN + 1);
  localparam int RET_W = $clog2(RETURN_RUN + 1);
  localparam int ARM_W = $clog2(ARM_EDGES + 1);

  // REF2 run length: a REF1 edge restarts it, a simultaneous REF2 edge counts after it
  function automatic logic [RUN_W-1:0] run_next(input logic [RUN_W-1:0] cur,
                                                input logic e1, input logic e2);
    if (e1)                                      return e2 ? RUN_W'(1) : '0;
    else if (e2 && (cur < RUN_W'(LOSS_RUN)))     return cur + RUN_W'(1);
    else                                         return cur;
  endfunction

  function automatic logic [RET_W-1:0] ret_next(input logic [RET_W-1:0] cur, input logic hit);
    return hit ? ((cur < RET_W'(RETURN_RUN)) ? cur + RET_W'(1) : cur) : cur;
  endfunction

  logic ref1_prev_q, ref2_prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref1_prev_q <= 1'b0;
      ref2_prev_q <= 1'b0;
    end else begin
      ref1_prev_q <= ref1_lvl;
      ref2_prev_q <= ref2_lvl;
    end
  end
  assign ref1_edge = ref1_lvl & ~ref1_prev_q;
  assign ref2_edge = ref2_lvl & ~ref2_prev_q;

  logic [RUN_W-1:0] run_q, run_d;
  logic [RET_W-1:0] ret_q, ret_d;
  logic [ARM_W-1:0] arm_q, arm_d;
  logic             lost_q, lost_d;
  logic             pend_q, pend_d;
  logic             tgt_q, tgt_d;
  logic             run_hit, lost_evt, ret_evt;

  always_comb begin
    run_d    = run_next(run_q, ref1_edge, ref2_edge);
    run_hit  = (run_d == RUN_W'(LOSS_RUN)) && (run_q != RUN_W'(LOSS_RUN));
    lost_evt = run_hit && !lost_q;
    ret_evt  = lost_q && !run_hit && ref1_edge && (ret_q == RET_W'(RETURN_RUN - 1));

    if (!lost_q || run_hit || ret_evt) ret_d = '0;
    else                                ret_d = ret_next(ret_q, ref1_edge);

    lost_d = lost_q;
    if (lost_evt)     lost_d = 1'b1;
    else if (ret_evt) lost_d = 1'b0;

    pend_d     = pend_q;
    tgt_d      = tgt_q;
    arm_d      = arm_q;
    sw_done    = 1'b0;
    sw_to_ref2 = tgt_q;
    if (lost_evt || ret_evt) begin
      pend_d = 1'b1;
      tgt_d  = lost_evt;
      arm_d  = ARM_W'(ARM_EDGES);
    end else if (pend_q && ref2_edge) begin
      if (arm_q == ARM_W'(1)) begin
        sw_done = 1'b1;
        pend_d  = 1'b0;
        arm_d   = '0;
      end else begin
        arm_d = arm_q - ARM_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      ret_q  <= '0;
      arm_q  <= '0;
      lost_q <= 1'b0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ret_q  <= ret_d;
      arm_q  <= arm_d;
      lost_q <= lost_d;
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
    end
  end

  assign lost = lost_q;

  a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(LOSS_RUN));

  a_r4_lost_rises_on_ref2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(lost_q)) |-> $past(ref2_edge));

  a_r7_lost_falls_on_ref1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(lost_q)) |-> $past(ref1_edge));

  a_r8_return_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ret_q < RET_W'(RETURN_RUN));

endmodule

// File: rtl/refsw_selector.sv
module refsw_selector
  import refsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  swo_ctrl_t ctrl,
  input  logic      pin_pick,
  input  logic      ref2_edge,
  input  logic      sw_done,
  input  logic      sw_to_ref2,
  output ref_pick_e pick,
  output logic      pick_chg
);

  function automatic ref_pick_e manual_pick(input swo_ctrl_t c, input logic pin);
    return ref_pick_e'(c.src_pin ? pin : c.reg_pick);
  endfunction

  function automatic ref_pick_e auto_pick(input ref_pick_e cur, input logic done,
                                          input logic to2, input logic hold);
    if (!done)    return cur;
    else if (to2) return PICK_REF2;
    else if (hold) return cur;
    else          return PICK_REF1;
  endfunction

  ref_pick_e pick_q, pick_d;
  logic      chg_q;

  always_comb begin
    if (ctrl.auto_en) pick_d = auto_pick(pick_q, sw_done, sw_to_ref2, ctrl.hold_ref2);
    else              pick_d = manual_pick(ctrl, pin_pick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pick_q <= PICK_REF1;
      chg_q  <= 1'b0;
    end else begin
      pick_q <= pick_d;
      chg_q  <= (pick_d != pick_q);
    end
  end

  assign pick     = pick_q;
  assign pick_chg = chg_q;

  a_r6_auto_change_after_ref2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl.auto_en) && (pick_q != $past(pick_q))) |-> $past(ref2_edge));

  a_r2_reg_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!ctrl.auto_en && !ctrl.src_pin)) |-> (pick_q == ref_pick_e'($past(ctrl.reg_pick))));

endmodule

// File: rtl/refclk_switchover.sv
module refclk_switchover
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_RUN    = 3,
  parameter int RETURN_RUN  = 4,
  parameter int ARM_EDGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref1_in,
  input  logic ref2_in,
  input  logic auto_en,
  input  logic revert_hold,
  input  logic man_src_pin,
  input  logic man_reg_sel,
  input  logic sel_pin,
  output logic sel_ref2,
  output logic sel_change,
  output logic ref1_lost
);

  localparam int N_ASYNC = 3;

  logic [N_ASYNC-1:0] async_bus, sync_bus;
  logic      ref1_edge, ref2_edge, sw_done, sw_to_ref2, lost;
  swo_ctrl_t ctrl;
  ref_pick_e pick;
  logic      pick_chg;

  assign async_bus = {sel_pin, ref2_in, ref1_in};

  assign ctrl.auto_en   = auto_en;
  assign ctrl.hold_ref2 = revert_hold;
  assign ctrl.src_pin   = man_src_pin;
  assign ctrl.reg_pick  = man_reg_sel;

  refsw_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (async_bus),
    .sync_out (sync_bus)
  );

  refsw_monitor #(.LOSS_RUN(LOSS_RUN), .RETURN_RUN(RETURN_RUN), .ARM_EDGES(ARM_EDGES)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref1_lvl   (sync_bus[0]),
    .ref2_lvl   (sync_bus[1]),
    .ref1_edge  (ref1_edge),
    .ref2_edge  (ref2_edge),
    .lost       (lost),
    .sw_done    (sw_done),
    .sw_to_ref2 (sw_to_ref2)
  );

  refsw_selector u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .pin_pick   (sync_bus[2]),
    .ref2_edge  (ref2_edge),
    .sw_done    (sw_done),
    .sw_to_ref2 (sw_to_ref2),
    .pick       (pick),
    .pick_chg   (pick_chg)
  );

  assign sel_ref2   = (pick == PICK_REF2);
  assign sel_change = pick_chg;
  assign ref1_lost  = lost;

  a_r11_pulse_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (sel_ref2 != $past(sel_ref2))) |-> sel_change);

  a_r11_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (sel_ref2 == $past(sel_ref2))) |-> !sel_change);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!sel_ref2 && !sel_change && !ref1_lost));

endmodule

// File: tb/refclk_switchover_tb.sv
module refclk_switchover_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref1_in = 1'b0, ref2_in = 1'b0;
  logic auto_en = 1'b0, revert_hold = 1'b0, man_src_pin = 1'b0, man_reg_sel = 1'b0, sel_pin = 1'b0;
  logic sel_ref2, sel_change, ref1_lost;

  int total = 0;
  int bad = 0;
  int pulse_err = 0;
  logic prev_sel = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  refclk_switchover u_dut (
    .clk(clk), .rst_n(rst_n), .ref1_in(ref1_in), .ref2_in(ref2_in),
    .auto_en(auto_en), .revert_hold(revert_hold), .man_src_pin(man_src_pin),
    .man_reg_sel(man_reg_sel), .sel_pin(sel_pin),
    .sel_ref2(sel_ref2), .sel_change(sel_change), .ref1_lost(ref1_lost)
  );

  // R11 monitor: the marker must coincide with each value change of the selection
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sel_change !== (sel_ref2 !== prev_sel)) pulse_err++;
    end
    prev_sel = sel_ref2;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref1_in = 1'b0; ref2_in = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic edge1();
    ref1_in = 1'b1; tick(4);
    ref1_in = 1'b0; tick(4);
  endtask

  task automatic edge2();
    ref2_in = 1'b1; tick(4);
    ref2_in = 1'b0; tick(4);
  endtask

  task automatic expect_state(input int exp_sel, input int exp_lost, input string req);
    @(negedge clk);
    check(sel_ref2 == exp_sel[0], req, sel_ref2, exp_sel);
    check(ref1_lost == exp_lost[0], req, ref1_lost, exp_lost);
    tick(0);
  endtask

  // bring the block into the lost state with REF2 selected
  task automatic drive_loss();
    for (int i = 0; i < 5; i++) edge2();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    tick(3);
    @(negedge clk);
    check(sel_ref2 == 1'b0 && sel_change == 1'b0 && ref1_lost == 1'b0, "R1 in reset",
          {sel_ref2, sel_change, ref1_lost}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_ref2 == 1'b0 && sel_change == 1'b0 && ref1_lost == 1'b0, "R1 after reset",
          {sel_ref2, sel_change, ref1_lost}, 0);
    tick(1);

    // R2: register select, pin ignored
    man_reg_sel = 1'b1; tick(6);
    expect_state(1, 0, "R2 reg=1");
    sel_pin = 1'b0; tick(6);
    expect_state(1, 0, "R2 pin ignored");
    man_reg_sel = 1'b0; sel_pin = 1'b1; tick(6);
    expect_state(0, 0, "R2 reg=0 pin=1");
    // loss detection in manual mode raises the flag but does not move the selection
    for (int i = 0; i < 5; i++) edge2();
    expect_state(0, 1, "R4 manual loss flag");

    // R3: pin select, register ignored
    do_reset();
    man_src_pin = 1'b1; sel_pin = 1'b1; tick(6);
    expect_state(1, 0, "R3 pin=1");
    man_reg_sel = 1'b0; tick(6);
    expect_state(1, 0, "R3 reg ignored");
    sel_pin = 1'b0; man_reg_sel = 1'b1; tick(6);
    expect_state(0, 0, "R3 pin=0");
    man_src_pin = 1'b0; man_reg_sel = 1'b0; sel_pin = 1'b0; tick(6);

    // R4/R6 sweep: k REF2 edges after reset in automatic mode
    auto_en = 1'b1;
    for (int k = 0; k <= 6; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) edge2();
      expect_state((k >= 5) ? 1 : 0, (k >= 3) ? 1 : 0, (k >= 5) ? "R6 sweep" : "R4 sweep");
    end

    // R5 sweep: j REF2 edges, a REF1 edge, then 2 more REF2 edges
    for (int j = 1; j <= 2; j++) begin
      do_reset();
      for (int i = 0; i < j; i++) edge2();
      edge1();
      edge2(); edge2();
      expect_state(0, 0, "R5 run restart");
    end

    // R7/R9: revertive recovery
    do_reset();
    revert_hold = 1'b0;
    drive_loss();
    expect_state(1, 1, "R6 lost");
    for (int m = 1; m <= 3; m++) begin
      edge1(); edge2();
      expect_state(1, 1, "R7 not yet returned");
    end
    edge1();
    expect_state(1, 0, "R7 returned");
    edge2();
    expect_state(1, 0, "R9 first REF2 edge");
    edge2();
    expect_state(0, 0, "R9 back to REF1");

    // R8: three-edge REF2 run restarts recovery count
    do_reset();
    drive_loss();
    edge1(); edge1(); edge1();
    edge2(); edge2(); edge2();
    edge1(); edge1(); edge1();
    expect_state(1, 1, "R8 count restarted");
    edge1();
    expect_state(1, 0, "R8 fourth after restart");

    // R10: non-revertive hold
    do_reset();
    revert_hold = 1'b1;
    drive_loss();
    edge1(); edge1(); edge1(); edge1();
    edge2(); edge2(); edge2();
    expect_state(1, 1, "R10 new loss while held");
    edge1(); edge1(); edge1(); edge1();
    edge2(); edge2();
    expect_state(1, 0, "R10 stays on REF2");
    auto_en = 1'b0; man_reg_sel = 1'b0; tick(6);
    expect_state(0, 0, "R10 manual return");

    // R11: change marker consistency over the whole run
    tick(4);
    check(pulse_err == 0, "R11 marker", pulse_err, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule